// File: doc/BRIEF.md
# Sparse Programmable Pulse Delay

This block reproduces each single-cycle pulse on its input a run-time programmable number of cycles later, for delays of up to 3454 cycles. Rather than keeping one bit per cycle of delay and picking the tap with a very wide multiplexer, it records, for every pulse it accepts, the tick at which that pulse is due. The record is a 12-bit timestamp held in a small addressed queue. The timestamp at the head of the queue is compared with a free-running tick counter. When they match, the block emits the delayed pulse and retires the entry.

The method rests on a density guarantee from the surrounding system: no more than QUEUE_DEPTH pulses may be pending at once. That holds when at most that many pulses arrive within any span as long as the delay. A pulse that arrives while the queue is full is discarded and raises a sticky overflow flag.

A clock enable qualifies every cycle. While the enable is low, time stands still for the block, so the delay is counted in enabled cycles. Reprogramming the delay empties the queue, so that due times stay in arrival order.

Top module: `sparse_pulse_delay`

## Requirements
- R1: While reset is low and after it is released, `pulse_out` and `overflow` are 0 and no pulses are pending.
- R2: A pulse sampled on an enabled edge with a programmed delay N in 1..3454 makes `pulse_out` high for exactly one cycle. That cycle follows the N-th enabled edge after the sampling edge.
- R3: When a pulse arrives while QUEUE_DEPTH pulses are pending (a pulse retiring in that same cycle does not free room for it), it is dropped and `overflow` goes high on the next cycle. The flag stays high until reset, and pulses already accepted are still delivered.
- R4: A programmed delay of 0 acts as a delay of 1. A programmed delay above 3454 acts as 3454.
- R5: While `ce` is low, `pulse_in` is ignored, the tick counter holds, and `pulse_out` is low on the following cycle. The delay therefore counts enabled edges only.
- R6: On an enabled edge where `delay_n` differs from its value at the previous enabled edge (0 just after reset), all pending pulses are discarded and `pulse_out` is low on the next cycle. A pulse sampled on that same edge is accepted with the new delay.
- R7: Many pulses may be pending at once, including pulses on consecutive cycles. Each is delivered at its own due time, in arrival order.
- R8: Delays whose due time wraps past the end of the 12-bit tick range are delivered at the correct cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; qualifies every cycle of the block |
| pulse_in | input | 1 | Pulse to delay, sampled on enabled edges |
| delay_n | input | 12 | Programmed delay in enabled cycles |
| pulse_out | output | 1 | Delayed pulse |
| overflow | output | 1 | Sticky flag: a pulse was dropped because the queue was full |

## Verification
The main function is exercised with several pulse trains:
- Sparse trains with a short delay show the basic latency.
- Back-to-back trains with a delay of 1 show that a pulse can be accepted and another retired in the same cycle.
- Dense trains with a medium delay keep several entries pending, which shows that retirement order is kept.
- A train that exactly fills the queue at the maximum delay runs past the tick counter's wrap point.

A delay of 0 and a delay above the maximum separate the clamping rule from plain pass-through. Directed cases then cover the following:
- gaps in the enable that stretch the delay
- a delay change with pulses in flight
- a delay change that coincides with a new pulse
- one pulse more than the queue holds, which must raise the flag without losing the queued ones

// File: rtl/spd_pkg.sv
package spd_pkg;

    // Width of the tick counter and of every stored due time.
    localparam int TS_W = 12;

    typedef logic [TS_W-1:0] ts_t;

    // Registered control state of the top level.
    typedef struct packed {
        logic pulse;   // delayed pulse being emitted
        logic ovf;     // sticky drop flag
        ts_t  last_n;  // delay seen on the previous enabled edge
    } ctl_state_t;

endpackage

// File: rtl/spd_tick_counter.sv
module spd_tick_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] tick
);

    logic [W-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (en) begin
            tick_d = tick_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/spd_delay_norm.sv
module spd_delay_norm #(
    parameter int W         = 12,
    parameter int MAX_DELAY = 3454
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);

    localparam logic [W-1:0] MAX_V = W'(MAX_DELAY);
    localparam logic [W-1:0] MIN_V = W'(1);

    // Zero becomes the one-cycle minimum; anything past the ceiling is clamped.
    always_comb begin
        if (raw == '0) begin
            eff = MIN_V;
        end else if (raw > MAX_V) begin
            eff = MAX_V;
        end else begin
            eff = raw;
        end
    end

endmodule

// File: rtl/spd_due_fifo.sv
module spd_due_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          p_d, p_q;
    logic [AW-1:0] waddr;
    logic [W-1:0]  mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
        return (a == AW'(DEPTH - 1)) ? '0 : a + AW'(1);
    endfunction

    always_comb begin
        p_d   = p_q;
        waddr = p_q.wr;
        if (flush) begin
            // Emptied queue; a simultaneous push lands in slot zero.
            waddr   = '0;
            p_d.rd  = '0;
            p_d.wr  = push ? bump('0) : '0;
            p_d.cnt = push ? CW'(1) : '0;
        end else begin
            if (push) begin
                p_d.wr = bump(p_q.wr);
            end
            if (pop) begin
                p_d.rd = bump(p_q.rd);
            end
            p_d.cnt = p_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[waddr] <= din;
        end
    end

    assign head  = mem[p_q.rd];
    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/sparse_pulse_delay.sv
module sparse_pulse_delay
    import spd_pkg::*;
#(
    parameter int MAX_DELAY   = 3454,
    parameter int QUEUE_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic            pulse_in,
    input  logic [TS_W-1:0] delay_n,
    output logic            pulse_out,
    output logic            overflow
);

    ctl_state_t st_d, st_q;

    ts_t  tick;
    ts_t  eff_delay;
    ts_t  due_at;
    ts_t  q_head;
    logic q_empty, q_full;
    logic n_change, due_now, take, drop;

    spd_tick_counter #(.W(TS_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ce),
        .tick  (tick)
    );

    spd_delay_norm #(.W(TS_W), .MAX_DELAY(MAX_DELAY)) u_norm (
        .raw (delay_n),
        .eff (eff_delay)
    );

    spd_due_fifo #(.DEPTH(QUEUE_DEPTH), .W(TS_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .pop   (due_now),
        .flush (n_change),
        .din   (due_at),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_comb begin
        n_change = ce && (delay_n != st_q.last_n);
        due_now  = ce && !n_change && !q_empty && (q_head == tick);
        take     = ce && pulse_in && (n_change || !q_full);
        drop     = ce && pulse_in && !n_change && q_full;
        due_at   = tick + eff_delay;

        st_d       = st_q;
        st_d.pulse = due_now;
        st_d.ovf   = st_q.ovf | drop;
        if (ce) begin
            st_d.last_n = delay_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_out = st_q.pulse;
    assign overflow  = st_q.ovf;

endmodule

// File: rtl/spd_checks.sv
module spd_checks
    import spd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ce,
    input logic            pulse_in,
    input logic [TS_W-1:0] delay_n,
    input logic            pulse_out,
    input logic            overflow
);

    // Delay value seen on the previous enabled edge, tracked from the ports.
    ts_t seen_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_n_q <= '0;
        end else if (ce) begin
            seen_n_q <= delay_n;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!pulse_out && !overflow));

    p_sticky_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(ce) && $past(pulse_in)));

    p_idle_no_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> !pulse_out);

    p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && (delay_n != seen_n_q)) |=> !pulse_out);

endmodule

bind sparse_pulse_delay spd_checks u_spd_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .pulse_in  (pulse_in),
    .delay_n   (delay_n),
    .pulse_out (pulse_out),
    .overflow  (overflow)
);

// File: tb/test_sparse_pulse_delay.sv
module test_sparse_pulse_delay;

    localparam int MAXD  = 3454;
    localparam int DEPTH = 8;

    typedef struct packed {
        logic [11:0] n;
        logic [7:0]  cnt;
        logic [11:0] gap;
    } vec_t;

    // delay, pulse count, pulse spacing
    localparam vec_t TBL [0:6] = '{
        '{12'd5,    8'd3,  12'd7},    // R2 sparse
        '{12'd20,   8'd6,  12'd2},    // R7 several in flight
        '{12'd1,    8'd10, 12'd1},    // R2 R7 back to back, minimum delay
        '{12'd0,    8'd4,  12'd3},    // R4 zero acts as one
        '{12'd3454, 8'd8,  12'd400},  // R8 maximum delay, queue exactly full, wraps tick
        '{12'd4000, 8'd2,  12'd50},   // R4 clamp to maximum
        '{12'd100,  8'd8,  12'd1}     // R7 eight consecutive
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        pulse_in = 1'b0;
    logic [11:0] delay_n = '0;
    logic        pulse_out, overflow;

    int checks = 0;
    int fails  = 0;
    int edge_no = 0;
    logic [4095:0] hist;

    always #4 clk = ~clk;

    sparse_pulse_delay #(.MAX_DELAY(MAXD), .QUEUE_DEPTH(DEPTH)) i_sparse_pulse_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .pulse_in  (pulse_in),
        .delay_n   (delay_n),
        .pulse_out (pulse_out),
        .overflow  (overflow)
    );

    function automatic int eff_of(input logic [11:0] n);
        if (n == 0) return 1;
        if (int'(n) > MAXD) return MAXD;
        return int'(n);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs, cross one rising edge, return at the following falling edge.
    task automatic step(input logic p, input logic c);
        pulse_in = p;
        ce       = c;
        @(posedge clk);
        edge_no++;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int highs, first_at, en_cnt, bad;
        @(negedge clk);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R1 pulse_out in reset", int'(pulse_out), 0);
        check("R1 overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b1);
        check("R1 pulse_out after release", int'(pulse_out), 0);

        // Table of pulse trains.
        for (int i = 0; i < 7; i++) begin
            int d, start, total, mism, seen, sent;
            logic p, exp;
            d = eff_of(TBL[i].n);
            delay_n = TBL[i].n;
            step(1'b0, 1'b1);
            start = edge_no;
            hist = '0;
            mism = 0; seen = 0; sent = 0;
            total = int'(TBL[i].cnt) * int'(TBL[i].gap) + d + 4;
            for (int k = 0; k < total; k++) begin
                p = (k < int'(TBL[i].cnt) * int'(TBL[i].gap)) && (k % int'(TBL[i].gap) == 0);
                step(p, 1'b1);
                hist[edge_no % 4096] = p;
                if (p) sent++;
                exp = (edge_no - d > start) ? hist[(edge_no - d) % 4096] : 1'b0;
                if (pulse_out !== exp) mism++;
                if (pulse_out === 1'b1) seen++;
            end
            check($sformatf("R2 R7 R8 vector %0d timing mismatches", i), mism, 0);
            check($sformatf("R7 vector %0d delivered count", i), seen, sent);
        end
        check("R3 no overflow within density", int'(overflow), 0);

        // R5: enable low freezes the block.
        delay_n = 12'd4;
        step(1'b0, 1'b1);
        for (int j = 0; j < 5; j++) step(1'b1, 1'b0);
        highs = 0;
        for (int j = 0; j < 12; j++) begin
            step(1'b0, 1'b1);
            if (pulse_out) highs++;
        end
        check("R5 pulses ignored while ce low", highs, 0);
        step(1'b1, 1'b1);
        en_cnt = 0; first_at = -1; bad = 0;
        for (int j = 0; j < 20; j++) begin
            logic c;
            c = (j % 2 == 1);
            step(1'b0, c);
            if (c) en_cnt++;
            if (!c && pulse_out) bad++;
            if (pulse_out && first_at < 0) first_at = en_cnt;
        end
        check("R5 delay counts enabled edges", first_at, 4);
        check("R5 no output after disabled edge", bad, 0);

        // R6: delay change discards pending pulses.
        delay_n = 12'd30;
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        for (int j = 0; j < 10; j++) step(1'b0, 1'b1);
        delay_n = 12'd31;
        highs = 0;
        for (int j = 0; j < 60; j++) begin
            step(1'b0, 1'b1);
            if (pulse_out) highs++;
        end
        check("R6 pending pulse discarded on change", highs, 0);
        delay_n = 12'd12;
        step(1'b1, 1'b1);
        begin
            int e0;
            e0 = edge_no; first_at = -1;
            for (int j = 0; j < 20; j++) begin
                step(1'b0, 1'b1);
                if (pulse_out && first_at < 0) first_at = edge_no - e0;
            end
        end
        check("R6 pulse on change edge uses new delay", first_at, 12);

        // R3: one pulse more than the queue holds.
        delay_n = 12'd200;
        step(1'b0, 1'b1);
        for (int j = 0; j < DEPTH; j++) step(1'b1, 1'b1);
        check("R3 no flag when exactly full", int'(overflow), 0);
        step(1'b1, 1'b1);
        check("R3 flag on dropped pulse", int'(overflow), 1);
        highs = 0;
        for (int j = 0; j < 215; j++) begin
            step(1'b0, 1'b1);
            if (pulse_out) highs++;
        end
        check("R3 queued pulses still delivered", highs, DEPTH);
        delay_n = 12'd9;
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R3 flag sticky", int'(overflow), 1);

        rst_n = 1'b0;
        step(1'b0, 1'b1);
        check("R1 reset clears flag", int'(overflow), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b1);
        check("R1 flag low after release", int'(overflow), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule